// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an internal bus master and an external asynchronous static RAM of 512K words by 16 bits. The master hands it single-word requests, each carrying a 19-bit word address, 16 bits of write data, a two-bit byte mask and a read/write flag. The block turns each request into a correctly timed sequence on the memory pins: chip select, output enable, write enable, the upper and lower byte enables, the address and the bidirectional data bus. Read data comes back on a response port with a one-cycle valid pulse.

Every analog timing window is converted to whole clock cycles at elaboration time. The conversion rounds up, and it uses the clock period and the nanosecond minima given as parameters. These windows are the access cycle time, the write-enable pulse width, the data setup before write enable rises, and the bus turnaround after a read. At a 10 ns clock the defaults give a 6-clock read window, a 1-clock write setup, a 5-clock write pulse and a 2-clock turnaround. All pin outputs come straight from flops.

Request side is valid/ready. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle, so the master must hold its request and all its fields stable until that edge. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the master must take `rsp_rdata` in that cycle.

Top module: `asram_access_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, and chip select, output enable, write enable and both byte enables are all high (inactive).
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` drops in the cycle after acceptance and stays low until the access and any turnaround are over.
- R3: For a read accepted at edge k, chip select and output enable are low from edge k until edge k+6. The data bus is sampled at edge k+6, and `rsp_valid` is high for exactly the one cycle that follows edge k+6.
- R4: Mask bit 1 selects the upper byte (data bits 15:8, upper enable) and mask bit 0 selects the lower byte (bits 7:0, lower enable). Only the byte enables of set mask bits go low. A read returns zero in unselected bytes, and a write leaves unselected bytes of the stored word unchanged.
- R5: For a write accepted at edge k, output enable stays high throughout. The write data is driven from edge k, write enable is low from edge k+1 to edge k+6 (5 cycles), and write enable, chip select and the data drive all release together at edge k+6.
- R6: Address and chip select stay constant for the whole access, and chip select is low for at least 6 cycles. After a write, `req_ready` returns after edge k+6. After a read, it returns after edge k+8.
- R7: After a read, the controller does not drive the data bus for 2 cycles after output enable rises. A write queued behind a read is accepted no earlier than 9 cycles after the read's acceptance, and the data bus is never driven while output enable is low.
- R8: A write with mask 00 asserts neither byte enable and leaves the stored word unchanged.
- R9: A request held valid while the controller is busy is accepted on the first edge after `req_ready` returns. A read queued behind a write is therefore accepted exactly 7 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
Each result is due a fixed number of edges after the acceptance edge k. The first pin changes appear after k, and write enable falls after k+1. Read data and `rsp_valid` appear after k+6, and write enable releases at k+6. `req_ready` returns after k+6 for a write and after k+8 for a read. The bench drives a request at a falling edge and marks the following rising edge as k. It then samples the pins and the response only at falling edges, naming each check by its offset from k, so every compare falls mid-cycle after the flop that produces it. Queued-request tests count falling edges with `req_ready` low to confirm the 7- and 9-cycle acceptance gaps. A memory model in the bench measures strobe widths at the pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_TURNAROUND
  } asram_state_e;

  // whole clock cycles covering a window in ns, rounded up
  function automatic int unsigned clocks_for(input int unsigned win_ns,
                                             input int unsigned period_ns);
    return (win_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_window_cnt.sv
module asram_window_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign done = (remain_q == '0);

endmodule

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] sel_mask,
  output logic [LANES-1:0] sel_en_n,
  input  logic [LANES-1:0] cap_mask,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    cap_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_en_n[g]                 = ~sel_mask[g];
    assign cap_data[g*LANE_W +: LANE_W] = cap_mask[g] ? bus_in[g*LANE_W +: LANE_W]
                                                      : {LANE_W{1'b0}};
  end

endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANES     = 2,
  parameter int unsigned READ_CLK  = 6,
  parameter int unsigned SETUP_CLK = 1,
  parameter int unsigned PULSE_CLK = 5,
  parameter int unsigned TURN_CLK  = 2,
  localparam int unsigned MAX_WIN  = umax(umax(READ_CLK, SETUP_CLK), umax(PULSE_CLK, TURN_CLK)),
  localparam int unsigned CNT_W    = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  lane_en_n_in,
  output logic [LANES-1:0]  lane_q,
  input  logic [DATA_W-1:0] cap_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [LANES-1:0]  lane_en_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dq_q,
  output logic              dq_drive
);

  localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CLK - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CLK - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CLK - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CLK - 1);

  asram_state_e     state_q, state_d;
  logic             win_load;
  logic [CNT_W-1:0] win_val;
  logic             win_done;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  asram_window_cnt #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_load),
    .load_val (win_val),
    .done     (win_done)
  );

  always_comb begin
    state_d  = state_q;
    win_load = 1'b0;
    win_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          win_load = 1'b1;
          if (req_write) begin
            state_d = ST_WRITE_SETUP;
            win_val = SETUP_LD;
          end else begin
            state_d = ST_READ_WAIT;
            win_val = READ_LD;
          end
        end
      end
      ST_READ_WAIT: begin
        if (win_done) begin
          state_d  = ST_TURNAROUND;
          win_load = 1'b1;
          win_val  = TURN_LD;
        end
      end
      ST_WRITE_SETUP: begin
        if (win_done) begin
          state_d  = ST_WRITE_PULSE;
          win_load = 1'b1;
          win_val  = PULSE_LD;
        end
      end
      ST_WRITE_PULSE: begin
        if (win_done) state_d = ST_IDLE;
      end
      ST_TURNAROUND: begin
        if (win_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      lane_en_n <= '1;
      lane_q    <= '0;
      addr_q    <= '0;
      dq_q      <= '0;
      dq_drive  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q    <= req_addr;
            cs_n      <= 1'b0;
            lane_en_n <= lane_en_n_in;
            lane_q    <= ~lane_en_n_in;
            if (req_write) begin
              dq_q     <= req_wdata;
              dq_drive <= 1'b1;
            end else begin
              oe_n <= 1'b0;
            end
          end
        end
        ST_READ_WAIT: begin
          if (win_done) begin
            rsp_rdata <= cap_data;
            rsp_valid <= 1'b1;
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            lane_en_n <= '1;
          end
        end
        ST_WRITE_SETUP: begin
          if (win_done) we_n <= 1'b0;
        end
        ST_WRITE_PULSE: begin
          if (win_done) begin
            we_n      <= 1'b1;
            cs_n      <= 1'b1;
            lane_en_n <= '1;
            dq_drive  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/asram_access_ctrl.sv
module asram_access_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_CYCLE_NS    = 55,
  parameter int unsigned T_WPULSE_NS   = 45,
  parameter int unsigned T_DSETUP_NS   = 25,
  parameter int unsigned T_TURN_NS     = 20,
  localparam int unsigned LANES        = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned CYC_RAW   = clocks_for(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_RAW    = clocks_for(T_WPULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_RAW    = clocks_for(T_DSETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN_RAW  = clocks_for(T_TURN_NS, CLK_PERIOD_NS);
  localparam int unsigned READ_CLK  = umax(1, CYC_RAW);
  localparam int unsigned SETUP_CLK = (CYC_RAW > WP_RAW) ? (CYC_RAW - WP_RAW) : 1;
  localparam int unsigned PULSE_CLK = umax(umax(1, WP_RAW),
                                           (DS_RAW > SETUP_CLK) ? (DS_RAW - SETUP_CLK) : 0);
  localparam int unsigned TURN_CLK  = umax(1, TURN_RAW);

  logic [LANES-1:0]  lane_sel_n;
  logic [LANES-1:0]  lane_q;
  logic [LANES-1:0]  lane_en_n;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] dq_q;
  logic              dq_drive;

  asram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .sel_mask (req_mask),
    .sel_en_n (lane_sel_n),
    .cap_mask (lane_q),
    .bus_in   (mem_dq),
    .cap_data (cap_data)
  );

  asram_seq_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .READ_CLK  (READ_CLK),
    .SETUP_CLK (SETUP_CLK),
    .PULSE_CLK (PULSE_CLK),
    .TURN_CLK  (TURN_CLK)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .lane_en_n_in (lane_sel_n),
    .lane_q       (lane_q),
    .cap_data     (cap_data),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .cs_n         (mem_cs_n),
    .oe_n         (mem_oe_n),
    .we_n         (mem_we_n),
    .lane_en_n    (lane_en_n),
    .addr_q       (mem_addr),
    .dq_q         (dq_q),
    .dq_drive     (dq_drive)
  );

  assign mem_ub_n = lane_en_n[LANES-1];
  assign mem_lb_n = lane_en_n[0];
  assign mem_dq   = dq_drive ? dq_q : {DATA_W{1'bz}};

endmodule

// File: rtl/asram_checks.sv
module asram_checks #(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned MASK_W        = 2,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_WPULSE_NS   = 45
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [MASK_W-1:0] req_mask,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dq_drive
);

  localparam int unsigned WP_MIN = (T_WPULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_cnt <= '0;
    else if (mem_we_n) we_low_cnt <= '0;
    else if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
  end

  // R1 / R2: an idle controller has every strobe released
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !dq_drive));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (mem_ub_n == !$past(req_mask[MASK_W-1]) && mem_lb_n == !$past(req_mask[0])));

  a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n && dq_drive));

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= WP_MIN[7:0]));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !dq_drive);

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !dq_drive);

  a_r9_write_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> mem_oe_n);

endmodule

bind asram_access_ctrl asram_checks #(
  .ADDR_W        (ADDR_W),
  .MASK_W        (LANES),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WPULSE_NS   (T_WPULSE_NS)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_mask  (req_mask),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_addr  (mem_addr),
  .dq_drive  (dq_drive)
);

// File: tb/tb_asram_access_ctrl.sv
module tb_asram_access_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [18:0] mem_addr;
  wire  [15:0] mem_dq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  asram_access_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq(mem_dq)
  );

  // memory model: 1024 words indexed by the low address bits
  logic [15:0] mem_arr [1024];
  assign mem_dq = (!mem_cs_n && !mem_oe_n) ? mem_arr[mem_addr[9:0]] : 16'bz;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin : model
    int we_low = 0;
    int cs_low = 0;
    logic [15:0] wd = '0;
    logic ub = 1'b1, lb = 1'b1;
    for (int i = 0; i < 1024; i++) mem_arr[i] = {i[7:0] ^ 8'hC3, i[7:0]};
    forever begin
      @(negedge clk);
      if (!mem_cs_n) cs_low++;
      else begin
        if (cs_low > 0) chk(cs_low >= 6, "R6", "model cs low cycles", cs_low, 6);
        cs_low = 0;
      end
      if (!mem_cs_n && !mem_we_n) begin
        if (we_low > 0) chk(mem_dq == wd, "R5", "model data stable in pulse", mem_dq, wd);
        we_low++;
        wd = mem_dq; ub = mem_ub_n; lb = mem_lb_n;
      end else if (we_low > 0) begin
        chk(we_low >= 5, "R5", "model write pulse cycles", we_low, 5);
        if (!ub) mem_arr[mem_addr[9:0]][15:8] = wd[15:8];
        if (!lb) mem_arr[mem_addr[9:0]][7:0]  = wd[7:0];
        we_low = 0;
      end
    end
  end

  // vector: {write, mask, addr, wdata, expected read}
  localparam int NV = 12;
  localparam logic [53:0] VEC [NV] = '{
    {1'b1, 2'b11, 19'h00010, 16'hA55A, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA55A},
    {1'b1, 2'b01, 19'h00010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA534},
    {1'b1, 2'b10, 19'h7FC21, 16'hBEEF, 16'h0000},
    {1'b0, 2'b01, 19'h7FC21, 16'h0000, 16'h0021},
    {1'b0, 2'b10, 19'h7FC21, 16'h0000, 16'hBE00},
    {1'b1, 2'b11, 19'h403FF, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 19'h403FF, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 19'h00200, 16'h0000, 16'hC300},
    {1'b0, 2'b11, 19'h0055A, 16'h0000, 16'h995A},
    {1'b0, 2'b11, 19'h7FC21, 16'h0000, 16'hBE21}
  };

  // present a request at a falling edge, return after its acceptance edge
  task automatic send(input bit w, input logic [1:0] m, input logic [18:0] a,
                      input logic [15:0] d, output int waits);
    req_write = w; req_mask = m; req_addr = a; req_wdata = d; req_valid = 1'b1;
    waits = 0;
    while (!req_ready) begin
      @(negedge clk);
      waits++;
    end
    @(posedge clk);
  endtask

  task automatic wait_rsp(input logic [15:0] exp, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        seen = 1'b1;
        chk(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
      end
    end
    if (!seen) chk(1'b0, req, "response missing", 0, 1);
  endtask

  task automatic run_vec(input logic [53:0] v);
    bit w = v[53];
    logic [1:0] m = v[52:51];
    logic [18:0] a = v[50:32];
    logic [15:0] d = v[31:16];
    logic [15:0] e = v[15:0];
    int waits;
    send(w, m, a, d, waits);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
        chk(mem_addr == a, "R6", "address", mem_addr, a);
        chk({mem_ub_n, mem_lb_n} == ~m, "R4", "byte enables", {mem_ub_n, mem_lb_n}, ~m);
        chk(mem_cs_n == 1'b0, "R6", "cs low", mem_cs_n, 0);
        chk(mem_we_n == 1'b1, "R5", "we high first cycle", mem_we_n, 1);
      end
      if (w) begin
        if (i == 1) begin
          chk(mem_oe_n == 1'b1, "R5", "oe high in write", mem_oe_n, 1);
          chk(mem_dq == d, "R5", "write data driven", mem_dq, d);
        end
        if (i == 2 || i == 6) chk(mem_we_n == 1'b0, "R5", "we low in pulse", mem_we_n, 0);
        if (i == 6) chk(req_ready == 1'b0, "R6", "ready still low", req_ready, 0);
        if (i == 7) begin
          chk(mem_we_n && mem_cs_n, "R5", "we/cs released", {mem_we_n, mem_cs_n}, 2'b11);
          chk(req_ready == 1'b1, "R6", "ready after write", req_ready, 1);
        end
      end else begin
        if (i == 1) chk(mem_oe_n == 1'b0, "R3", "oe low in read", mem_oe_n, 0);
        if (i == 6) chk(rsp_valid == 1'b0, "R3", "rsp not early", rsp_valid, 0);
        if (i == 7) begin
          chk(rsp_valid == 1'b1, "R3", "rsp pulse", rsp_valid, 1);
          chk(rsp_rdata == e, "R4", "masked read data", rsp_rdata, e);
          chk(mem_oe_n && mem_cs_n, "R7", "oe/cs released", {mem_oe_n, mem_cs_n}, 2'b11);
        end
        if (i == 8) begin
          chk(rsp_valid == 1'b0, "R3", "rsp one cycle", rsp_valid, 0);
          chk(req_ready == 1'b0, "R7", "ready low in turnaround", req_ready, 0);
        end
        if (i == 9) chk(req_ready == 1'b1, "R6", "ready after read", req_ready, 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int waits;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1",
        "strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
    chk(rsp_valid == 1'b0, "R1", "rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_cs_n, "R1", "idle after reset", {req_ready, mem_cs_n}, 2'b11);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R8: empty mask write leaves the word alone
    send(1'b1, 2'b00, 19'h00010, 16'hFFFF, waits);
    @(negedge clk);
    req_valid = 1'b0;
    chk({mem_ub_n, mem_lb_n} == 2'b11, "R8", "no lane enabled", {mem_ub_n, mem_lb_n}, 2'b11);
    send(1'b0, 2'b11, 19'h00010, 16'h0000, waits);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(16'hA534, "R8");

    // R9: read queued behind a write
    while (!req_ready) @(negedge clk);
    send(1'b1, 2'b11, 19'h00123, 16'h0F0F, waits);
    @(negedge clk);
    send(1'b0, 2'b11, 19'h00123, 16'h0000, waits);
    chk(waits == 6, "R9", "read accept gap minus one", waits, 6);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(16'h0F0F, "R9");

    // R7: write queued behind a read
    while (!req_ready) @(negedge clk);
    send(1'b0, 2'b11, 19'h00123, 16'h0000, waits);
    @(negedge clk);
    send(1'b1, 2'b11, 19'h00123, 16'hF00F, waits);
    chk(waits == 8, "R7", "write accept gap minus one", waits, 8);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    send(1'b0, 2'b11, 19'h00123, 16'h0000, waits);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(16'hF00F, "R7");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule